// File: doc/BRIEF.md
# Buffered Input Capture Holding Logic

This block holds the result registers of one input-capture channel. A capture register records the free-running main timer value on every qualified pin edge. An 8-bit pulse accumulator counts those same edges. Each of the two values has a holding register behind it, so software can read a stable earlier value while new edges keep arriving.

How the holding registers fill depends on a mode input, and only while the buffer-enable input is set.

- **Queue mode:** every new capture pushes the previous capture value into the holding register.
- **Latch mode:** the holding registers take a snapshot of the capture register and the accumulator when a latch event occurs. A latch event is one of three things:
  - the modulus down-counter reaching zero;
  - a zero being written to the modulus count;
  - a software latch strobe.

  The same event clears the accumulator.

Edge qualification, the modulus counter and the register interface sit outside the block. They reach it only as single-cycle strobes and level controls.

Top module: `ic_hold_unit`

## Requirements
- R1: When `rst_n` is low at a clock edge, all four outputs read zero after that edge.
- R2: A cycle with `cap_edge` high loads `timer_val` into `cap_q`, whatever the mode and buffer-enable values.
- R3: With `buf_en` low, `hold_q` and `acc_hold_q` never change. The three latch sources then neither transfer anything nor clear `acc_q`.
- R4: With `buf_en` high and `latch_mode` = 0 (queue), a `cap_edge` cycle moves the old `cap_q` into `hold_q` while `cap_q` takes the new timer value.
- R5: With `latch_mode` = 1, a capture edge with no latch event leaves `hold_q` unchanged.
- R6: With `buf_en` and `latch_mode` both high, a cycle with any of `mod_zero`, `mod_wr_zero` or `sw_latch` high copies `cap_q` to `hold_q` and `acc_q` to `acc_hold_q`.
- R7: A latch event sets `acc_q` to zero after its value is transferred. The clear wins over an edge in the same cycle.
- R8: Without a latch event, each `cap_edge` adds one to `acc_q`. The count holds at 255 instead of wrapping.
- R9: When a capture edge and a latch event share a cycle, `hold_q` gets the pre-capture `cap_q` and `cap_q` gets the new timer value.
- R10: With `latch_mode` = 0, the three latch sources have no effect on `hold_q`, `acc_hold_q` or `acc_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_val | input | TW (16) | Free-running main timer value |
| cap_edge | input | 1 | Qualified pin edge strobe, one cycle |
| mod_zero | input | 1 | Modulus down-counter reached zero |
| mod_wr_zero | input | 1 | Zero written to the modulus count |
| sw_latch | input | 1 | Software latch strobe |
| buf_en | input | 1 | Enables both holding behaviours |
| latch_mode | input | 1 | 0 selects queue mode, 1 selects latch mode |
| cap_q | output | TW (16) | Capture register |
| hold_q | output | TW (16) | Capture holding register |
| acc_q | output | AW (8) | Pulse accumulator |
| acc_hold_q | output | AW (8) | Accumulator holding register |

## Verification
A table walks the channel through four patterns:
- queue-mode edge trains, which show that the shift uses the old capture value and not the new one;
- edges with buffering off, which separate capture from transfer;
- latch-mode edges separated by each of the three latch sources in turn, which show that each source alone triggers the snapshot and the clear;
- a capture coinciding with a latch, which fixes the ordering inside one cycle.

Latch sources applied in queue mode and with buffering off confirm that they do nothing there. A long edge train without latches checks saturation, and a following latch shows that the saturated count is transferred intact.

// File: rtl/ic_hold_pkg.sv
// Package: shared types for the input-capture holding logic.
// Assumes: one mode bit, where 0 selects queue and 1 selects latch.
package ic_hold_pkg;

    typedef enum logic {
        MODE_QUEUE = 1'b0,
        MODE_LATCH = 1'b1
    } hold_mode_e;

endpackage

// File: rtl/ic_event_decode.sv
// Module: turns the control levels and strobes into the two internal
// transfer commands: a queue shift and a latch snapshot.
// Assumes: all strobes are single-cycle and synchronous to clk.
module ic_event_decode
    import ic_hold_pkg::*;
(
    input  logic buf_en,
    input  logic latch_mode,
    input  logic cap_edge,
    input  logic mod_zero,
    input  logic mod_wr_zero,
    input  logic sw_latch,
    output logic queue_shift,
    output logic latch_evt
);

    hold_mode_e mode;
    logic       any_source;

    // Map the raw mode bit onto the enum and gather the latch sources.
    always_comb begin
        mode       = hold_mode_e'(latch_mode);
        any_source = mod_zero | mod_wr_zero | sw_latch;
    end

    // Produce a command only while buffering is enabled in the matching mode.
    always_comb begin
        queue_shift = buf_en && (mode == MODE_QUEUE) && cap_edge;
        latch_evt   = buf_en && (mode == MODE_LATCH) && any_source;
    end

endmodule

// File: rtl/ic_capture_stage.sv
// Module: the capture register and its holding register.
// Assumes: queue_shift and latch_evt are never high together (the decoder
// guarantees this). Both commands load the holding register from the
// pre-edge capture value.
module ic_capture_stage #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          cap_edge,
    input  logic          queue_shift,
    input  logic          latch_evt,
    output logic [TW-1:0] cap_q,
    output logic [TW-1:0] hold_q
);

    logic hold_load;

    // Either command moves the current capture value into the holding register.
    always_comb hold_load = queue_shift | latch_evt;

    // Capture register: records the timer on each qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (cap_edge)
            cap_q <= timer_val;
    end

    // Holding register: loads the pre-edge capture value on a command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (hold_load)
            hold_q <= cap_q;
    end

endmodule

// File: rtl/ic_pulse_acc.sv
// Module: saturating pulse accumulator and its holding register.
// Assumes: on a latch event the clear takes priority over a count edge
// in the same cycle.
module ic_pulse_acc #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_edge,
    input  logic          latch_evt,
    output logic [AW-1:0] acc_q,
    output logic [AW-1:0] acc_hold_q
);

    localparam logic [AW-1:0] ACC_MAX = {AW{1'b1}};

    logic at_max;

    // Flag the ceiling so that the counter stops there.
    always_comb at_max = (acc_q == ACC_MAX);

    // Accumulator: clear on a latch, otherwise count up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (latch_evt)
            acc_q <= '0;
        else if (cnt_edge && !at_max)
            acc_q <= acc_q + 1'b1;
    end

    // Holding register: snapshot of the count taken before the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_hold_q <= '0;
        else if (latch_evt)
            acc_hold_q <= acc_q;
    end

endmodule

// File: rtl/ic_hold_unit.sv
// Module: top of the buffered input-capture holding logic. It joins the
// event decoder, the capture stage and the pulse accumulator.
// Assumes: cap_edge is already filtered and qualified. The modulus events
// come from a counter outside this block.
module ic_hold_unit #(
    parameter int TW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          cap_edge,
    input  logic          mod_zero,
    input  logic          mod_wr_zero,
    input  logic          sw_latch,
    input  logic          buf_en,
    input  logic          latch_mode,
    output logic [TW-1:0] cap_q,
    output logic [TW-1:0] hold_q,
    output logic [AW-1:0] acc_q,
    output logic [AW-1:0] acc_hold_q
);

    logic queue_shift;
    logic latch_evt;

    ic_event_decode u_decode (
        .buf_en      (buf_en),
        .latch_mode  (latch_mode),
        .cap_edge    (cap_edge),
        .mod_zero    (mod_zero),
        .mod_wr_zero (mod_wr_zero),
        .sw_latch    (sw_latch),
        .queue_shift (queue_shift),
        .latch_evt   (latch_evt)
    );

    ic_capture_stage #(.TW(TW)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_val   (timer_val),
        .cap_edge    (cap_edge),
        .queue_shift (queue_shift),
        .latch_evt   (latch_evt),
        .cap_q       (cap_q),
        .hold_q      (hold_q)
    );

    ic_pulse_acc #(.AW(AW)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_edge    (cap_edge),
        .latch_evt   (latch_evt),
        .acc_q       (acc_q),
        .acc_hold_q  (acc_hold_q)
    );

endmodule

// File: rtl/ic_hold_unit_chk.sv
// Checker: port-level properties of ic_hold_unit, attached by bind.
// Assumes: the same parameters as the bound instance.
module ic_hold_unit_chk #(
    parameter int TW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] timer_val,
    input logic          cap_edge,
    input logic          mod_zero,
    input logic          mod_wr_zero,
    input logic          sw_latch,
    input logic          buf_en,
    input logic          latch_mode,
    input logic [TW-1:0] cap_q,
    input logic [TW-1:0] hold_q,
    input logic [AW-1:0] acc_q,
    input logic [AW-1:0] acc_hold_q
);

    localparam logic [AW-1:0] ACC_MAX = {AW{1'b1}};

    logic src;
    logic snap;

    // Port-level view of the latch sources and of a qualifying latch.
    always_comb begin
        src  = mod_zero | mod_wr_zero | sw_latch;
        snap = buf_en && latch_mode && src;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (cap_q == '0 && hold_q == '0 && acc_q == '0 && acc_hold_q == '0));

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_edge |=> cap_q == $past(timer_val));

    p_no_buffer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en |=> ($stable(hold_q) && $stable(acc_hold_q)));

    p_queue_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !latch_mode && cap_edge) |=> hold_q == $past(cap_q));

    p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && !src) |=> $stable(hold_q));

    p_snapshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (hold_q == $past(cap_q) && acc_hold_q == $past(acc_q)));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> acc_q == '0);

    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == ACC_MAX && !snap) |=> acc_q == ACC_MAX);

    p_queue_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !cap_edge) |=> ($stable(hold_q) && $stable(acc_hold_q) && $stable(acc_q)));

endmodule

bind ic_hold_unit ic_hold_unit_chk #(.TW(TW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .timer_val   (timer_val),
    .cap_edge    (cap_edge),
    .mod_zero    (mod_zero),
    .mod_wr_zero (mod_wr_zero),
    .sw_latch    (sw_latch),
    .buf_en      (buf_en),
    .latch_mode  (latch_mode),
    .cap_q       (cap_q),
    .hold_q      (hold_q),
    .acc_q       (acc_q),
    .acc_hold_q  (acc_hold_q)
);

// File: tb/ic_hold_unit_bench.sv
// Bench: a vector table walked by one loop, then directed tests for
// saturation and reset.
module ic_hold_unit_bench;

    localparam int TW = 16;
    localparam int AW = 8;
    localparam int NV = 13;

    // Vector layout: {edge, mz, wz, sw, buf, mode, timer, cap, hold, acc, acc_hold}
    localparam logic [69:0] VEC [NV] = '{
        {6'b100010, 16'h0011, 16'h0011, 16'h0000, 8'h01, 8'h00}, // R4 first edge
        {6'b100010, 16'h0022, 16'h0022, 16'h0011, 8'h02, 8'h00}, // R4 shift
        {6'b000010, 16'h0099, 16'h0022, 16'h0011, 8'h02, 8'h00}, // R2 idle
        {6'b100000, 16'h0033, 16'h0033, 16'h0011, 8'h03, 8'h00}, // R3 no shift
        {6'b000101, 16'h0000, 16'h0033, 16'h0011, 8'h03, 8'h00}, // R3 sw ignored
        {6'b100011, 16'h0044, 16'h0044, 16'h0011, 8'h04, 8'h00}, // R5 keep hold
        {6'b010011, 16'h0000, 16'h0044, 16'h0044, 8'h00, 8'h04}, // R6 R7 mod zero
        {6'b100011, 16'h0055, 16'h0055, 16'h0044, 8'h01, 8'h04}, // R8 count
        {6'b001011, 16'h0000, 16'h0055, 16'h0055, 8'h00, 8'h01}, // R6 write zero
        {6'b100011, 16'h0066, 16'h0066, 16'h0055, 8'h01, 8'h01}, // R5
        {6'b100111, 16'h0077, 16'h0077, 16'h0066, 8'h00, 8'h01}, // R9 R7 same cycle
        {6'b010010, 16'h0000, 16'h0077, 16'h0066, 8'h00, 8'h01}, // R10 mz in queue
        {6'b000110, 16'h0000, 16'h0077, 16'h0066, 8'h00, 8'h01}  // R10 sw in queue
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] timer_val;
    logic          cap_edge, mod_zero, mod_wr_zero, sw_latch, buf_en, latch_mode;
    logic [TW-1:0] cap_q, hold_q;
    logic [AW-1:0] acc_q, acc_hold_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ic_hold_unit #(.TW(TW), .AW(AW)) u_ic_hold_unit (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_edge(cap_edge),
        .mod_zero(mod_zero), .mod_wr_zero(mod_wr_zero), .sw_latch(sw_latch),
        .buf_en(buf_en), .latch_mode(latch_mode), .cap_q(cap_q), .hold_q(hold_q),
        .acc_q(acc_q), .acc_hold_q(acc_hold_q)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive the inputs on the falling edge, let one rising edge pass, then sample.
    task automatic step(input logic [5:0] ctl, input logic [TW-1:0] t);
        {cap_edge, mod_zero, mod_wr_zero, sw_latch, buf_en, latch_mode} = ctl;
        timer_val = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        @(negedge clk);
        step(6'b000000, '0);
        step(6'b000000, '0);
        check("R1", "cap", 32'(cap_q), 32'h0);
        check("R1", "hold", 32'(hold_q), 32'h0);
        check("R1", "acc", 32'(acc_q), 32'h0);
        check("R1", "acc_hold", 32'(acc_hold_q), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][69:64], VEC[i][63:48]);
            check($sformatf("R2-vec%0d", i), "cap", 32'(cap_q), 32'(VEC[i][47:32]));
            check($sformatf("R4R6-vec%0d", i), "hold", 32'(hold_q), 32'(VEC[i][31:16]));
            check($sformatf("R7R8-vec%0d", i), "acc", 32'(acc_q), 32'(VEC[i][15:8]));
            check($sformatf("R6-vec%0d", i), "acc_hold", 32'(acc_hold_q), 32'(VEC[i][7:0]));
        end

        // R8: a long edge train with buffering off stops at the ceiling.
        for (int i = 0; i < 300; i++) step(6'b100000, 16'(i));
        check("R8", "acc saturated", 32'(acc_q), 32'hFF);
        check("R3", "hold frozen", 32'(hold_q), 32'h0066);
        check("R2", "last capture", 32'(cap_q), 32'(299));

        // R6/R7: a software latch in latch mode transfers the full count, then clears.
        step(6'b000111, '0);
        check("R6", "acc_hold after saturation", 32'(acc_hold_q), 32'hFF);
        check("R7", "acc cleared", 32'(acc_q), 32'h0);
        check("R6", "hold snapshot", 32'(hold_q), 32'(299));

        // R1: a reset in mid-run returns everything to zero.
        rst_n = 1'b0;
        step(6'b000000, '0);
        check("R1", "cap after reset", 32'(cap_q), 32'h0);
        check("R1", "hold after reset", 32'(hold_q), 32'h0);
        check("R1", "acc_hold after reset", 32'(acc_hold_q), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule